// File: doc/BRIEF.md
# Bang-Bang Clock Recovery Phase Loop

This block is the digital loop of a receiver that samples every incoming symbol twice. It takes a data sample at the centre of the symbol and an edge sample at the boundary just before it. It compares the current data bit, the previous data bit and the edge bit between them. From these it decides whether the sampling clock sits early or late, or whether it has nothing to learn because the data did not toggle.

The decisions go into a signed vote counter. The counter is cleared each time it emits a step. A step moves an 8-bit phase register by one position. That register is the control word for an external phase interpolator. The loop is first order, so it has no frequency-tracking term. The recovered bit is also returned, registered.

A synchronous restart input reloads the phase register from a supplied start code. It also clears the vote counter and the transition history. Symbols are presented under a per-cycle strobe, and cycles without the strobe leave the loop state untouched.

Top module: `cdr_bb_loop`

## Requirements
- R1: While `rst_n` is low, and until the first symbol after reset, `phase_code` is the parameter `PHASE_RST` (default 0), and `step_up`, `step_dn` and `rx_bit_vld` are 0.
- R2: A strobed symbol whose data bit equals the previous strobed data bit casts no vote. So does the first symbol after reset or restart. Such symbols never cause a step.
- R3: A strobed symbol whose data bit differs from the previous one casts a late vote (-1) if `edge_smp` equals the new data bit. It casts an early vote (+1) if `edge_smp` equals the previous data bit.
- R4: The vote sum is signed. When a vote brings it to +4, `step_up` is high for exactly the next cycle; when a vote brings it to -4, `step_dn` is high for exactly the next cycle. Either event resets the sum to 0. The two pulses are never high together.
- R5: In the cycle after `step_up` is high, `phase_code` has grown by one. In the cycle after `step_dn` is high, it has fallen by one. Otherwise, without restart, it holds.
- R6: `phase_code` wraps modulo 256: one up step from 255 gives 0, and one down step from 0 gives 255.
- R7: `restart` high at a clock edge loads `init_code` into `phase_code`, clears the vote sum and the transition history, drops both step pulses and drops `rx_bit_vld`. It takes priority over a symbol in the same cycle.
- R8: In the cycle after a strobed symbol, `rx_bit` equals that symbol's `data_smp` and `rx_bit_vld` is 1. In the cycle after a cycle without the strobe, `rx_bit_vld` is 0.
- R9: Cycles with `sym_vld` low change neither the vote sum nor the previous-bit history.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Loop clock, one symbol per strobed cycle |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| restart | input | 1 | Synchronous reload of phase and clearing of loop state |
| init_code | input | 8 | Phase code loaded on restart |
| sym_vld | input | 1 | Strobe: a symbol's samples are present this cycle |
| data_smp | input | 1 | Data-centre sample of the symbol |
| edge_smp | input | 1 | Edge sample preceding the data sample |
| rx_bit | output | 1 | Recovered data bit |
| rx_bit_vld | output | 1 | Recovered bit is fresh this cycle |
| step_up | output | 1 | One-cycle pulse: phase advanced |
| step_dn | output | 1 | One-cycle pulse: phase retarded |
| phase_code | output | 8 | Phase interpolator control code |

## Verification
The bench keeps its own record of the vote sum and the previous bit, and compares every output on every cycle. A vote sum that drifts by even one inside the block moves the next step pulse by at least one symbol. That shift shows on `step_up` or `step_dn` within four transitions, and on `phase_code` one cycle later. A lost transition history shows as a missing or extra vote on the next toggling symbol. A wrong wrap or load value shows as a wrong `phase_code` on the cycle right after the step or restart.

// File: rtl/cdr_bb_pkg.sv
package cdr_bb_pkg;
  typedef enum logic [1:0] {
    VOTE_HOLD  = 2'b00,
    VOTE_EARLY = 2'b01,
    VOTE_LATE  = 2'b10
  } vote_e;
endpackage

// File: rtl/cdr_rst_sync.sv
module cdr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/cdr_phase_det.sv
module cdr_phase_det
  import cdr_bb_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  restart,
  input  logic  sym_vld,
  input  logic  data_smp,
  input  logic  edge_smp,
  output vote_e vote,
  output logic  vote_vld,
  output logic  rx_bit,
  output logic  rx_bit_vld
);
  logic prev_q, prev_d;
  logic hist_q, hist_d;
  logic rxb_q, rxb_d;
  logic rxv_q, rxv_d;
  logic smp_en;

  // decision from current bit, previous bit and the edge between them
  always_comb begin
    if (data_smp == prev_q) vote = VOTE_HOLD;
    else if (edge_smp == data_smp) vote = VOTE_LATE;
    else vote = VOTE_EARLY;
  end

  assign vote_vld = sym_vld & hist_q & ~restart;
  assign smp_en   = restart | sym_vld;

  always_comb begin
    prev_d = prev_q;
    hist_d = hist_q;
    rxb_d  = rxb_q;
    rxv_d  = 1'b0;
    if (restart) begin
      hist_d = 1'b0;
    end else if (sym_vld) begin
      prev_d = data_smp;
      hist_d = 1'b1;
      rxb_d  = data_smp;
      rxv_d  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      hist_q <= 1'b0;
      rxb_q  <= 1'b0;
      rxv_q  <= 1'b0;
    end else begin
      rxv_q <= rxv_d;
      if (smp_en) begin
        prev_q <= prev_d;
        hist_q <= hist_d;
        rxb_q  <= rxb_d;
      end
    end
  end

  assign rx_bit     = rxb_q;
  assign rx_bit_vld = rxv_q;

  assert_rx_follows_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_bit_vld |-> ($past(sym_vld) && !$past(restart) && rx_bit == $past(data_smp)));
endmodule

// File: rtl/cdr_vote_filter.sv
module cdr_vote_filter
  import cdr_bb_pkg::*;
#(
  parameter int VOTE_LEN = 4
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  restart,
  input  logic  vote_vld,
  input  vote_e vote,
  output logic  step_up,
  output logic  step_dn
);
  localparam int SUM_W = $clog2(VOTE_LEN) + 2;
  localparam logic signed [SUM_W-1:0] LIM_P = SUM_W'(VOTE_LEN);
  localparam logic signed [SUM_W-1:0] LIM_N = -LIM_P;

  logic signed [SUM_W-1:0] sum_q, sum_d, sum_try, inc;
  logic up_q, up_d, dn_q, dn_d;
  logic sum_en;

  always_comb begin
    case (vote)
      VOTE_EARLY: inc = SUM_W'(1);
      VOTE_LATE:  inc = -SUM_W'(1);
      default:    inc = '0;
    endcase
    sum_try = sum_q + inc;
  end

  always_comb begin
    sum_d = sum_q;
    up_d  = 1'b0;
    dn_d  = 1'b0;
    if (restart) begin
      sum_d = '0;
    end else if (vote_vld) begin
      if (sum_try >= LIM_P) begin
        up_d  = 1'b1;
        sum_d = '0;
      end else if (sum_try <= LIM_N) begin
        dn_d  = 1'b1;
        sum_d = '0;
      end else begin
        sum_d = sum_try;
      end
    end
  end

  assign sum_en = restart | vote_vld;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum_q <= '0;
      up_q  <= 1'b0;
      dn_q  <= 1'b0;
    end else begin
      up_q <= up_d;
      dn_q <= dn_d;
      if (sum_en) sum_q <= sum_d;
    end
  end

  assign step_up = up_q;
  assign step_dn = dn_q;

  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (sum_q > LIM_N) && (sum_q < LIM_P));
  assert_step_needs_vote_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (step_up || step_dn) |-> ($past(vote_vld) && !$past(restart)));
endmodule

// File: rtl/cdr_phase_acc.sv
module cdr_phase_acc #(
  parameter int PHASE_W   = 8,
  parameter int PHASE_RST = 0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               restart,
  input  logic [PHASE_W-1:0] init_code,
  input  logic               step_up,
  input  logic               step_dn,
  output logic [PHASE_W-1:0] phase_code
);
  localparam logic [PHASE_W-1:0] ONE   = PHASE_W'(1);
  localparam logic [PHASE_W-1:0] RST_V = PHASE_W'(PHASE_RST);

  logic [PHASE_W-1:0] ph_q, ph_d;
  logic ph_en;

  // modulo arithmetic: natural wrap of a PHASE_W-bit register
  always_comb begin
    if (restart)      ph_d = init_code;
    else if (step_up) ph_d = ph_q + ONE;
    else if (step_dn) ph_d = ph_q - ONE;
    else              ph_d = ph_q;
  end

  assign ph_en = restart | step_up | step_dn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ph_q <= RST_V;
    else if (ph_en) ph_q <= ph_d;
  end

  assign phase_code = ph_q;

  assert_up_one_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (step_up && !restart) |=> phase_code == PHASE_W'($past(phase_code) + ONE));
  assert_dn_one_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (step_dn && !restart) |=> phase_code == PHASE_W'($past(phase_code) - ONE));
  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!step_up && !step_dn && !restart) |=> $stable(phase_code));
  assert_reload_R7: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> phase_code == $past(init_code));
endmodule

// File: rtl/cdr_bb_loop.sv
module cdr_bb_loop
  import cdr_bb_pkg::*;
#(
  parameter int PHASE_W   = 8,
  parameter int VOTE_LEN  = 4,
  parameter int PHASE_RST = 0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               restart,
  input  logic [PHASE_W-1:0] init_code,
  input  logic               sym_vld,
  input  logic               data_smp,
  input  logic               edge_smp,
  output logic               rx_bit,
  output logic               rx_bit_vld,
  output logic               step_up,
  output logic               step_dn,
  output logic [PHASE_W-1:0] phase_code
);
  logic  rst_n_i;
  vote_e vote;
  logic  vote_vld;

  cdr_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_i)
  );

  cdr_phase_det u_det (
    .clk(clk), .rst_n(rst_n_i), .restart(restart), .sym_vld(sym_vld),
    .data_smp(data_smp), .edge_smp(edge_smp), .vote(vote), .vote_vld(vote_vld),
    .rx_bit(rx_bit), .rx_bit_vld(rx_bit_vld)
  );

  cdr_vote_filter #(.VOTE_LEN(VOTE_LEN)) u_flt (
    .clk(clk), .rst_n(rst_n_i), .restart(restart), .vote_vld(vote_vld),
    .vote(vote), .step_up(step_up), .step_dn(step_dn)
  );

  cdr_phase_acc #(.PHASE_W(PHASE_W), .PHASE_RST(PHASE_RST)) u_acc (
    .clk(clk), .rst_n(rst_n_i), .restart(restart), .init_code(init_code),
    .step_up(step_up), .step_dn(step_dn), .phase_code(phase_code)
  );

  assert_pulses_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n_i)
    !(step_up && step_dn));
endmodule

// File: tb/sim_cdr_bb_loop.sv
module sim_cdr_bb_loop;
  logic clk = 1'b0;
  logic rst_n, restart, sym_vld, data_smp, edge_smp;
  logic [7:0] init_code;
  logic rx_bit, rx_bit_vld, step_up, step_dn;
  logic [7:0] phase_code;

  int n_chk = 0, n_bad = 0;
  int cnt_up = 0, cnt_dn = 0;
  bit done = 0;

  int m_sum, m_phase;
  bit m_prev, m_hist, m_up, m_dn, m_rx, m_rxv;
  bit lastd;

  always #10 clk = ~clk;

  cdr_bb_loop u0 (
    .clk(clk), .rst_n(rst_n), .restart(restart), .init_code(init_code),
    .sym_vld(sym_vld), .data_smp(data_smp), .edge_smp(edge_smp),
    .rx_bit(rx_bit), .rx_bit_vld(rx_bit_vld), .step_up(step_up),
    .step_dn(step_dn), .phase_code(phase_code)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0d exp=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int vote_of(bit hist, bit prev, bit d, bit e);
    if (!hist || d == prev) return 0;
    return (e == d) ? -1 : 1;
  endfunction

  task automatic tick(input bit r, input logic [7:0] ic, input bit v, input bit d, input bit e);
    int nph, ns;
    restart = r; init_code = ic; sym_vld = v; data_smp = d; edge_smp = e;
    nph = m_phase;
    if (r) nph = ic;
    else if (m_up) nph = (m_phase + 1) % 256;
    else if (m_dn) nph = (m_phase + 255) % 256;
    if (r) begin
      m_sum = 0; m_hist = 0; m_up = 0; m_dn = 0; m_rxv = 0;
    end else if (v) begin
      ns = m_sum + vote_of(m_hist, m_prev, d, e);
      m_up = 0; m_dn = 0;
      if (ns >= 4) begin m_up = 1; m_sum = 0; end
      else if (ns <= -4) begin m_dn = 1; m_sum = 0; end
      else m_sum = ns;
      m_rx = d; m_rxv = 1; m_prev = d; m_hist = 1;
    end else begin
      m_up = 0; m_dn = 0; m_rxv = 0;
    end
    m_phase = nph;
    @(posedge clk);
    @(negedge clk);
    if (step_up) cnt_up++;
    if (step_dn) cnt_dn++;
    check(phase_code == 8'(m_phase), "R5 phase_code", phase_code, m_phase);
    check(step_up == m_up && step_dn == m_dn, "R4 step_up/step_dn",
          {step_up, step_dn}, {m_up, m_dn});
    check(rx_bit_vld == m_rxv && (!m_rxv || rx_bit == m_rx), "R8 rx_bit/rx_bit_vld",
          {rx_bit_vld, rx_bit}, {m_rxv, m_rx});
  endtask

  task automatic idle(); tick(0, 8'd0, 0, 0, 0); endtask
  task automatic reload(input logic [7:0] ic); tick(1, ic, 0, 0, 0); endtask
  task automatic sym_late();  lastd = ~lastd; tick(0, 8'd0, 1, lastd, lastd);  endtask
  task automatic sym_early(); lastd = ~lastd; tick(0, 8'd0, 1, lastd, ~lastd); endtask

  initial begin
    #(20 * 200000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    int su, sd, mode;
    void'($urandom(32'd20240408));
    rst_n = 0; restart = 0; sym_vld = 0; data_smp = 0; edge_smp = 0; init_code = 0;
    m_sum = 0; m_phase = 0; m_prev = 0; m_hist = 0; m_up = 0; m_dn = 0; m_rx = 0; m_rxv = 0;
    lastd = 0;
    repeat (3) @(negedge clk);
    // R1: values held in reset
    check(phase_code == 8'd0 && !step_up && !step_dn && !rx_bit_vld, "R1 reset state",
          {phase_code, step_up, step_dn, rx_bit_vld}, 0);
    rst_n = 1;
    repeat (4) idle();
    check(phase_code == 8'd0 && !rx_bit_vld, "R1 after release", phase_code, 0);

    // R2: no transitions, no votes
    reload(8'd10);
    su = cnt_up; sd = cnt_dn;
    for (int i = 0; i < 12; i++) tick(0, 8'd0, 1, 1'b1, 1'($urandom_range(1)));
    idle();
    check(cnt_up == su && cnt_dn == sd, "R2 no step without transitions", cnt_up + cnt_dn, su + sd);
    check(phase_code == 8'd10, "R2 phase unchanged", phase_code, 10);

    // R3 + R6: late stream from code 0 -> one down step -> 255
    reload(8'd0);
    sd = cnt_dn;
    repeat (5) sym_late();
    check(cnt_dn == sd + 1, "R3 late votes give one down step", cnt_dn - sd, 1);
    idle();
    check(phase_code == 8'd255, "R6 wrap below zero", phase_code, 255);

    // R3 + R6: early stream from 255 -> one up step -> 0
    reload(8'd255);
    su = cnt_up;
    repeat (5) sym_early();
    check(cnt_up == su + 1, "R3 early votes give one up step", cnt_up - su, 1);
    idle();
    check(phase_code == 8'd0, "R6 wrap above 255", phase_code, 0);

    // R7: restart clears a partial sum and the history
    reload(8'd20);
    repeat (4) sym_early();
    reload(8'd50);
    idle();
    check(phase_code == 8'd50, "R7 reload code", phase_code, 50);
    su = cnt_up;
    repeat (2) sym_early();
    idle();
    check(cnt_up == su, "R7 sum cleared by restart", cnt_up - su, 0);

    // R9: idle cycles keep sum and history
    reload(8'd30);
    repeat (4) sym_early();
    su = cnt_up;
    repeat (10) idle();
    check(cnt_up == su, "R9 no step while idle", cnt_up - su, 0);
    sym_early();
    check(cnt_up == su + 1, "R9 fourth vote after gap steps", cnt_up - su, 1);
    idle();
    check(phase_code == 8'd31, "R9 phase after step", phase_code, 31);

    // constrained random: biased edge offsets, gaps, rare restarts
    mode = 0;
    for (int i = 0; i < 6000; i++) begin
      bit d, e, v, r;
      if (i % 200 == 0) mode = $urandom_range(2);
      r = ($urandom_range(499) == 0);
      v = ($urandom_range(9) < 8);
      d = 1'($urandom_range(1));
      case (mode)
        0: e = ($urandom_range(99) < 85) ? d : m_prev;
        1: e = ($urandom_range(99) < 85) ? m_prev : d;
        default: e = 1'($urandom_range(1));
      endcase
      tick(r, 8'($urandom_range(255)), v, d, e);
    end
    check(cnt_up > 0 && cnt_dn > 0, "R4 both step kinds seen", cnt_up + cnt_dn, 2);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule